// File: doc/BRIEF.md
# Scalar Coefficient Quantizer

This block turns signed integer transform coefficients into quantized levels. Each transfer carries one half of a 4x4 block, which is eight coefficients, together with a quantization parameter (QP) and an intra/inter flag. For every coefficient the block does four things:

- It picks a multiplication factor from a small constant table. The table is addressed by the coefficient's position class and by QP mod 6.
- It multiplies the factor by the coefficient magnitude and adds a rounding offset whose size depends on the block type.
- It shifts the sum right by a QP-dependent amount.
- It puts the original sign back.

A full 4x4 block leaves the block every two clocks.

The block sits in a transform pipeline, between a forward transform that produces eight coefficients per clock and a scan/entropy stage. Both the input and the output are valid/ready streams:

- A beat transfers on a rising edge where valid and ready are both high.
- While the output holds a beat that has not transferred, that beat and its flags stay unchanged.
- In that state the two internal stages freeze and `in_ready` is low.
- When `out_ready` is high, `in_ready` is high and one beat moves per clock.

Top module: `coef_quantizer`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Each output level has magnitude `(|W|*MF + f) >> qbits`, with `qbits = 15 + QP/6` (integer division). MF comes from position class and `QP mod 6` (0..5) as follows: even class {13107, 11916, 10082, 9362, 8192, 7282}; odd class {5243, 4660, 4194, 3647, 3355, 2893}; mixed class {8066, 7490, 6554, 5825, 5243, 4559}.
- R3: Lane k occupies bits `[16*k+15:16*k]` of the coefficient and level buses. It sits at row `2*half + k/4` and column `k%4`. Its class is even when both row and column are even, odd when both are odd, and mixed otherwise.
- R4: The rounding offset `f` is `floor(2^qbits/3)` when `in_intra` is 1 and `floor(2^qbits/6)` when it is 0.
- R5: The output sign equals the input sign, and a zero magnitude yields level 0. Levels are 16-bit two's complement.
- R6: A QP value above 51 gives exactly the result of QP 51.
- R7: If the output is not stalled, a beat accepted on a rising edge is presented on the outputs two clocks after the cycle in which it was offered. `out_half` repeats that beat's `in_half`.
- R8: With `out_ready` held high, `in_ready` stays high and consecutive beats come out on consecutive clocks, which is eight levels per clock.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_level` and `out_half` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| in_half | input | 1 | 0: rows 0-1 of the 4x4 block, 1: rows 2-3 |
| in_qp | input | 6 | Quantization parameter, 0..51 |
| in_intra | input | 1 | 1 for intra blocks, 0 for inter blocks |
| in_coef | input | 128 | Eight signed 16-bit coefficients, lane k in bits 16k+15:16k |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Output beat can be taken |
| out_half | output | 1 | Half flag of the output beat |
| out_level | output | 128 | Eight signed 16-bit levels, same lane order |

## Verification
The bench sweeps every QP from 0 to 51 in both modes, which exposes any wrong table entry, a wrong shift at a QP/6 boundary, or swapped intra/inter offsets. It also sends coefficients near zero, where a wrong sign step would produce negative zeros or a level of -1 in place of 0. The most negative coefficient is included, since a wrong magnitude width would overflow it. QP values 52 and 63 catch a missing clamp, which would shift too far and pick the wrong factor. Finally the bench holds `out_ready` low and then runs a back-to-back burst: a design that loses or repeats beats under back-pressure, or that leaves bubbles in the stream, fails the beat-by-beat comparison or the run-length check.

// File: rtl/qz_pkg.sv
package qz_pkg;

  typedef enum logic [1:0] {
    CLS_EVEN  = 2'd0,
    CLS_ODD   = 2'd1,
    CLS_MIXED = 2'd2
  } pos_class_e;

  localparam int MF_W = 14;

  // class of a lane from its row/column parity inside a two-row half
  function automatic pos_class_e lane_class(input int k, input int row_len);
    int rp;
    int cp;
    rp = (k / row_len) % 2;
    cp = (k % row_len) % 2;
    if (rp == 0 && cp == 0) return CLS_EVEN;
    if (rp == 1 && cp == 1) return CLS_ODD;
    return CLS_MIXED;
  endfunction

  function automatic logic [MF_W-1:0] mf_lookup(input pos_class_e c, input logic [2:0] m);
    logic [MF_W-1:0] r;
    r = '0;
    unique case (c)
      CLS_EVEN: case (m)
        3'd0: r = 14'd13107; 3'd1: r = 14'd11916; 3'd2: r = 14'd10082;
        3'd3: r = 14'd9362;  3'd4: r = 14'd8192;  default: r = 14'd7282;
      endcase
      CLS_ODD: case (m)
        3'd0: r = 14'd5243;  3'd1: r = 14'd4660;  3'd2: r = 14'd4194;
        3'd3: r = 14'd3647;  3'd4: r = 14'd3355;  default: r = 14'd2893;
      endcase
      default: case (m)
        3'd0: r = 14'd8066;  3'd1: r = 14'd7490;  3'd2: r = 14'd6554;
        3'd3: r = 14'd5825;  3'd4: r = 14'd5243;  default: r = 14'd4559;
      endcase
    endcase
    return r;
  endfunction

endpackage

// File: rtl/qz_qp_decode.sv
module qz_qp_decode #(
  parameter int QP_W       = 6,
  parameter int QP_MAX     = 51,
  parameter int QBITS_BASE = 15,
  parameter int QB_W       = 5,
  parameter int PW         = 30
) (
  input  logic [QP_W-1:0] qp,
  input  logic            intra,
  output logic [2:0]      qp_mod,
  output logic [QB_W-1:0] qbits,
  output logic [PW-1:0]   offset
);
  logic [QP_W-1:0] qp_c;
  logic [QP_W-1:0] qp_div;
  logic [QP_W-1:0] qp_rem;
  logic [PW-1:0]   span;

  always_comb begin
    qp_c   = (qp > QP_W'(QP_MAX)) ? QP_W'(QP_MAX) : qp;
    qp_div = qp_c / QP_W'(6);
    qp_rem = qp_c % QP_W'(6);
    qp_mod = qp_rem[2:0];
    qbits  = QB_W'(QBITS_BASE) + QB_W'(qp_div);
    span   = PW'(1) << qbits;
    offset = intra ? (span / PW'(3)) : (span / PW'(6));
  end

endmodule

// File: rtl/qz_lane.sv
module qz_lane
  import qz_pkg::*;
#(
  parameter int         CW   = 16,
  parameter int         PW   = 30,
  parameter int         QB_W = 5,
  parameter pos_class_e CLS  = CLS_EVEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            s1_valid,
  input  logic [CW-1:0]   coef,
  input  logic [2:0]      qp_mod,
  input  logic [QB_W-1:0] s1_qbits,
  input  logic [PW-1:0]   s1_offset,
  output logic [CW-1:0]   level
);
  logic [CW-1:0]   mag;
  logic [MF_W-1:0] mf;
  logic [PW-1:0]   prod;
  logic            neg1;
  logic [CW-1:0]   mag1;
  logic [PW-1:0]   prod1;
  logic [PW:0]     rounded;
  logic [CW-1:0]   lvl_mag;
  logic [CW-1:0]   lvl_abs;

  always_comb begin
    mag  = coef[CW-1] ? (~coef + 1'b1) : coef;
    mf   = mf_lookup(CLS, qp_mod);
    prod = PW'(mag) * PW'(mf);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      neg1  <= 1'b0;
      mag1  <= '0;
      prod1 <= '0;
    end else if (en) begin
      neg1  <= coef[CW-1];
      mag1  <= mag;
      prod1 <= prod;
    end
  end

  always_comb begin
    rounded = {1'b0, prod1} + {1'b0, s1_offset};
    lvl_mag = CW'(rounded >> s1_qbits);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  level <= '0;
    else if (en) level <= neg1 ? (~lvl_mag + 1'b1) : lvl_mag;
  end

  assign lvl_abs = level[CW-1] ? (~level + 1'b1) : level;

  // R5: sign of the level follows the coefficient; zero stays positive
  a_r5_sign: assert property (@(posedge clk) disable iff (!rst_n)
    en && s1_valid |=> (level == '0) || (level[CW-1] == $past(neg1)));

  // R2: factor below 2^15 and offset below 2^qbits keep the level at most |W|
  a_r2_bound: assert property (@(posedge clk) disable iff (!rst_n)
    en && s1_valid |=> lvl_abs <= $past(mag1));

endmodule

// File: rtl/coef_quantizer.sv
module coef_quantizer
  import qz_pkg::*;
#(
  parameter int CW         = 16,
  parameter int LANES      = 8,
  parameter int ROW_LEN    = 4,
  parameter int QP_W       = 6,
  parameter int QP_MAX     = 51,
  parameter int QBITS_BASE = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_half,
  input  logic [QP_W-1:0]     in_qp,
  input  logic                in_intra,
  input  logic [LANES*CW-1:0] in_coef,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_half,
  output logic [LANES*CW-1:0] out_level
);
  localparam int PW   = CW + MF_W;
  localparam int QB_W = $clog2(QBITS_BASE + QP_MAX / 6 + 1);

  logic            en;
  logic [2:0]      qp_mod;
  logic [QB_W-1:0] qbits;
  logic [PW-1:0]   offset;
  logic            s1_valid;
  logic            s1_half;
  logic [QB_W-1:0] s1_qbits;
  logic [PW-1:0]   s1_offset;

  // whole pipe advances unless a finished beat is waiting
  assign en       = !out_valid || out_ready;
  assign in_ready = en;

  qz_qp_decode #(
    .QP_W(QP_W), .QP_MAX(QP_MAX), .QBITS_BASE(QBITS_BASE), .QB_W(QB_W), .PW(PW)
  ) u_dec (
    .qp(in_qp), .intra(in_intra), .qp_mod(qp_mod), .qbits(qbits), .offset(offset)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_half   <= 1'b0;
      s1_qbits  <= '0;
      s1_offset <= '0;
      out_valid <= 1'b0;
      out_half  <= 1'b0;
    end else if (en) begin
      s1_valid  <= in_valid;
      s1_half   <= in_half;
      s1_qbits  <= qbits;
      s1_offset <= offset;
      out_valid <= s1_valid;
      out_half  <= s1_half;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam pos_class_e CLS = lane_class(k, ROW_LEN);
    qz_lane #(.CW(CW), .PW(PW), .QB_W(QB_W), .CLS(CLS)) u_lane (
      .clk(clk), .rst_n(rst_n), .en(en), .s1_valid(s1_valid),
      .coef(in_coef[k*CW +: CW]), .qp_mod(qp_mod),
      .s1_qbits(s1_qbits), .s1_offset(s1_offset),
      .level(out_level[k*CW +: CW])
    );
  end

  // R9: an untaken output beat is held
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_level) && $stable(out_half));

  // R9: no input taken while the output is blocked
  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R7: an accepted beat occupies the first stage next cycle
  a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_valid);

endmodule

// File: tb/coef_quantizer_test.sv
`timescale 1ns/1ps
module coef_quantizer_test;
  localparam int CW = 16;
  localparam int LANES = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic in_half = 1'b0;
  logic [5:0] in_qp = '0;
  logic in_intra = 1'b0;
  logic [LANES*CW-1:0] in_coef = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_half;
  logic [LANES*CW-1:0] out_level;

  int n_cmp = 0;
  int n_bad = 0;
  int run_len = 0;
  int max_run = 0;
  int stall_cnt = 0;
  bit done = 0;

  logic [LANES*CW-1:0] exp_q[$];
  logic exp_half_q[$];
  string tag_q[$];
  string cur_tag = "R2";

  int mf_even[6] = '{13107, 11916, 10082, 9362, 8192, 7282};
  int mf_odd[6]  = '{5243, 4660, 4194, 3647, 3355, 2893};
  int mf_mix[6]  = '{8066, 7490, 6554, 5825, 5243, 4559};

  always #2.5 clk = ~clk;

  coef_quantizer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_half(in_half), .in_qp(in_qp), .in_intra(in_intra), .in_coef(in_coef),
    .out_valid(out_valid), .out_ready(out_ready), .out_half(out_half),
    .out_level(out_level)
  );

  function automatic logic [CW-1:0] ref_level(input logic [CW-1:0] w, input int qp,
                                               input bit intra, input int k);
    int q, qb, m, mf, rp, cp;
    longint mag, f, lv;
    q  = (qp > 51) ? 51 : qp;
    qb = 15 + q / 6;
    m  = q % 6;
    rp = (k / 4) % 2;
    cp = k % 2;
    if (rp == 0 && cp == 0) mf = mf_even[m];
    else if (rp == 1 && cp == 1) mf = mf_odd[m];
    else mf = mf_mix[m];
    mag = longint'(signed'(w));
    if (mag < 0) mag = -mag;
    f  = (longint'(1) << qb) / (intra ? 3 : 6);
    lv = (mag * mf + f) >> qb;
    if (w[CW-1]) lv = -lv;
    return CW'(lv);
  endfunction

  function automatic logic [LANES*CW-1:0] ref_beat(input logic [LANES*CW-1:0] c,
                                                   input int qp, input bit intra);
    logic [LANES*CW-1:0] r;
    for (int k = 0; k < LANES; k++) r[k*CW +: CW] = ref_level(c[k*CW +: CW], qp, intra, k);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [LANES*CW-1:0] act,
                       input logic [LANES*CW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // scoreboard: sampled between edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        run_len++;
        if (run_len > max_run) max_run = run_len;
      end else run_len = 0;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(0, "R7 unexpected beat", out_level, '0);
        else begin
          logic [LANES*CW-1:0] e;
          logic eh;
          string t;
          e = exp_q.pop_front();
          eh = exp_half_q.pop_front();
          t = tag_q.pop_front();
          check(out_level == e, t, out_level, e);
          check(out_half == eh, "R7 half flag", LANES*CW'(out_half), LANES*CW'(eh));
        end
      end
      if (in_valid && !in_ready) stall_cnt++;
      if (in_valid && in_ready) begin
        exp_q.push_back(ref_beat(in_coef, int'(in_qp), in_intra));
        exp_half_q.push_back(in_half);
        tag_q.push_back(cur_tag);
      end
    end
  end

  task automatic send(input logic [LANES*CW-1:0] c, input int qp, input bit intra, input bit half);
    @(posedge clk); #1;
    in_valid = 1'b1; in_coef = c; in_qp = 6'(qp); in_intra = intra; in_half = half;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    check(exp_q.size() == 0, "R7 drain", LANES*CW'(exp_q.size()), '0);
  endtask

  function automatic logic [LANES*CW-1:0] pattern(input int seed);
    logic [LANES*CW-1:0] r;
    for (int k = 0; k < LANES; k++) begin
      int v;
      v = ((seed * 7919 + k * 4513) % 60001) - 30000;
      r[k*CW +: CW] = CW'(v);
    end
    return r;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 in reset", {out_valid, in_ready}, 2'b01);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 after reset", {out_valid, in_ready}, 2'b01);
  endtask

  task automatic t_qp_sweep();
    cur_tag = "R2 R3 R4 qp sweep";
    for (int qp = 0; qp < 52; qp++)
      for (int md = 0; md < 2; md++) begin
        send(pattern(qp * 2 + md), qp, bit'(md), 1'b0);
        send(pattern(qp * 2 + md + 500), qp, bit'(md), 1'b1);
      end
    idle();
    drain();
  endtask

  task automatic t_sign_zero();
    logic [LANES*CW-1:0] c;
    cur_tag = "R5 sign and zero";
    for (int k = 0; k < LANES; k++) c[k*CW +: CW] = CW'(k - 4);
    for (int qp = 0; qp < 12; qp += 3) begin
      send(c, qp, 1'b1, 1'b0);
      send(c, qp, 1'b0, 1'b1);
    end
    idle();
    drain();
  endtask

  task automatic t_extremes();
    logic [LANES*CW-1:0] c;
    cur_tag = "R2 extreme magnitude";
    for (int k = 0; k < LANES; k++) c[k*CW +: CW] = (k % 2) ? 16'h8000 : 16'h7fff;
    send(c, 0, 1'b1, 1'b0);
    send(c, 0, 1'b0, 1'b1);
    send(c, 51, 1'b1, 1'b0);
    idle();
    drain();
  endtask

  task automatic t_qp_clamp();
    cur_tag = "R6 qp above 51";
    send(pattern(77), 52, 1'b1, 1'b0);
    send(pattern(78), 63, 1'b0, 1'b1);
    idle();
    drain();
  endtask

  task automatic t_latency();
    cur_tag = "R7 latency";
    @(posedge clk); #1;
    in_valid = 1'b1; in_coef = pattern(9); in_qp = 6'd20; in_intra = 1'b1; in_half = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R7 cycle 0", LANES*CW'(out_valid), '0);
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R7 cycle 1", LANES*CW'(out_valid), '0);
    @(negedge clk);
    check(out_valid == 1'b1 && out_half == 1'b1, "R7 cycle 2", {out_valid, out_half}, 2'b11);
    drain();
  endtask

  task automatic t_backpressure();
    logic [LANES*CW-1:0] held;
    cur_tag = "R9 backpressure data";
    @(posedge clk); #1;
    out_ready = 1'b0;
    send(pattern(301), 10, 1'b1, 1'b0);
    send(pattern(302), 11, 1'b0, 1'b1);
    @(posedge clk); #1;
    in_coef = pattern(303); in_qp = 6'd40; in_half = 1'b0;
    @(negedge clk);
    held = out_level;
    for (int i = 0; i < 4; i++) begin
      check(out_valid == 1'b1 && in_ready == 1'b0, "R9 blocked", {out_valid, in_ready}, 2'b10);
      check(out_level == held, "R9 held level", out_level, held);
      @(negedge clk);
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    @(negedge clk);
    idle();
    drain();
  endtask

  task automatic t_throughput();
    int s0;
    cur_tag = "R8 burst";
    s0 = stall_cnt;
    max_run = 0;
    for (int b = 0; b < 16; b++) send(pattern(600 + b), b * 3, bit'(b % 2), bit'(b % 2));
    idle();
    drain();
    check(stall_cnt == s0, "R8 no input stall", LANES*CW'(stall_cnt - s0), '0);
    check(max_run >= 16, "R8 back-to-back output", LANES*CW'(max_run), LANES*CW'(16));
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_latency();
    t_qp_sweep();
    t_sign_zero();
    t_extremes();
    t_qp_clamp();
    t_backpressure();
    t_throughput();
    finish_run();
  end

endmodule